// File: doc/BRIEF.md
# PLL Frequency-Update SPI Sequencer

This block reprograms an external fractional-N clock synthesizer over a three-wire SPI bus. A single start strobe supplies the divider set: a reference doubler flag, an 8-bit integer divider, a 20-bit modulus, a 20-bit fractional numerator and two post dividers. The block checks these values, packs them into nine PLL control register bytes and sends them in one streaming write. Around that write it runs a fixed order of single-byte writes that hand VCO calibration to the serial port, commit buffered registers and request calibration.

Every transaction is one chip-select frame. A single-byte write is the header byte 0x00, then the register address, then the data. The streaming write starts with header 0x60 and address 0x19, and the device counts the address down from there. `busy` covers the whole sequence and `done` marks its end. A bad parameter set is refused with a one-cycle error pulse.

Top module: `pll_freq_seq`

## Requirements
- R1: When `start` is sampled while idle and any parameter is out of range (`postDivA` outside 4..11, `postDivB` equal to 0, or `intDiv` below 64), `paramErr` pulses high for exactly one cycle, no frame is sent, `spiCsN` stays high and `busy` stays low. Valid parameters never raise `paramErr`.
- R2: When `refDouble` is 1, the first frame is the single-byte write 00 1D 04. When `refDouble` is 0, that frame is not sent.
- R3: The remaining frames always come in this order: 00 0E 74 (calibration handed to SPI), commit, streaming write, commit, 00 0E F4 (calibration request), commit. So a sequence has 7 frames with the doubler and 6 without.
- R4: Each commit frame is exactly the three bytes 00 05 01.
- R5: The streaming frame is 11 bytes long: 60 19, then the register bytes in descending address order, from register 0x19 down to register 0x11.
- R6: The register bytes are: 0x19 = 0x80; 0x18 = {P1[4:0], (P0-4)[2:0]}; 0x17 = {FRAC[3:0], 3'b000, P1[5]}; 0x16 = FRAC[11:4]; 0x15 = FRAC[19:12]; 0x13 = MOD[11:4]; 0x12 = MOD[19:12]; 0x11 = N.
- R7: Register 0x14 is {MOD[3:0], 4'hE} when FRAC is zero, which bypasses the modulator, and {MOD[3:0], 4'h8} otherwise.
- R8: Data goes out MSB first. `spiSclk` idles low and is low whenever `spiCsN` is high. `spiMosi` changes only while `spiSclk` is low, so a receiver samples it on the rising edge.
- R9: Between two frames of one sequence, `spiCsN` stays high for at least 4*HALF_DIV clock cycles, which is two SPI clock periods.
- R10: `busy` is high from the cycle after an accepted start until the final commit's chip select rises. In that same cycle `done` pulses for exactly one cycle. After reset `busy` and `done` are low and `spiCsN` is high.
- R11: A `start` pulse while `busy` is high has no effect. The frames of the running sequence keep the originally captured values, and no extra sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frequency update |
| refDouble | input | 1 | 1 selects the reference doubler write |
| intDiv | input | 8 | Integer feedback divider N |
| fracMod | input | 20 | Modulator modulus MOD |
| fracNum | input | 20 | Modulator numerator FRAC |
| postDivA | input | 4 | Output divider P0 (4..11) |
| postDivB | input | 6 | Output divider P1 (1..63) |
| spiCsN | output | 1 | Active-low chip select |
| spiSclk | output | 1 | Serial clock, idle low |
| spiMosi | output | 1 | Serial data to the synthesizer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| paramErr | output | 1 | One-cycle parameter rejection pulse |

## Verification
A wrong transaction index or byte counter in the controller shows on the bus within the frame concerned: a frame ends up too long or too short, a header or register byte is swapped, or the frame count does not match the doubler setting. A broken bit counter or tick phase corrupts the MSB-first byte values or moves data while the clock is high, and the error shows at the very next SPI edge. A bad completion state shows within one cycle of the last chip-select rise, as a missing, repeated or mistimed `done` pulse or a `busy` that never falls.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int NUM_TXN    = 7;
  localparam int STREAM_TXN = 3;
  localparam int LAST_TXN   = NUM_TXN - 1;
  localparam int TXN_W      = $clog2(NUM_TXN);
  localparam int IDX_W      = 4;

  typedef struct packed {
    logic             latch;      // capture parameters
    logic             load;       // load next byte, drop chip select, clock low
    logic             rise;       // serial clock high
    logic             fall;       // serial clock low and advance one bit
    logic             csRelease;  // chip select high
    logic [TXN_W-1:0] txn;
    logic [IDX_W-1:0] byteIdx;
  } seqCmd_t;
endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqCmd_t     cmd,
  input  logic [7:0]  intDiv,
  input  logic [19:0] fracMod,
  input  logic [19:0] fracNum,
  input  logic [3:0]  postDivA,
  input  logic [5:0]  postDivB,
  output logic        paramOk,
  output logic        spiCsN,
  output logic        spiSclk,
  output logic        spiMosi
);
  localparam int NUM_REGS = 9;

  logic [7:0]  nLat;
  logic [19:0] modLat, fracLat;
  logic [3:0]  p0Lat;
  logic [5:0]  p1Lat;
  logic [7:0]  shiftReg;
  logic [7:0]  regByte [NUM_REGS];
  logic [7:0]  nextByte;
  logic [3:0]  p0Code;

  assign paramOk = (intDiv >= 8'd64) && (postDivA >= 4'd4) && (postDivA <= 4'd11)
                   && (postDivB != 6'd0);

  assign p0Code = p0Lat - 4'd4;

  // regByte[k] holds register 0x11 + k
  always_comb begin
    regByte[0] = nLat;
    regByte[1] = modLat[19:12];
    regByte[2] = modLat[11:4];
    regByte[3] = {modLat[3:0], (fracLat == 20'd0) ? 4'hE : 4'h8};
    regByte[4] = fracLat[19:12];
    regByte[5] = fracLat[11:4];
    regByte[6] = {fracLat[3:0], 3'b000, p1Lat[5]};
    regByte[7] = {p1Lat[4:0], p0Code[2:0]};
    regByte[8] = 8'h80;
  end

  always_comb begin
    logic [7:0] addr, data;
    unique case (cmd.txn)
      TXN_W'(0): begin addr = 8'h1D; data = 8'h04; end
      TXN_W'(1): begin addr = 8'h0E; data = 8'h74; end
      TXN_W'(5): begin addr = 8'h0E; data = 8'hF4; end
      default:   begin addr = 8'h05; data = 8'h01; end
    endcase
    if (cmd.txn == TXN_W'(STREAM_TXN)) begin
      if (cmd.byteIdx == 4'd0)      nextByte = 8'h60;
      else if (cmd.byteIdx == 4'd1) nextByte = 8'h19;
      else                          nextByte = regByte[4'd10 - cmd.byteIdx];
    end else begin
      if (cmd.byteIdx == 4'd0)      nextByte = 8'h00;
      else if (cmd.byteIdx == 4'd1) nextByte = addr;
      else                          nextByte = data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nLat <= '0; modLat <= '0; fracLat <= '0; p0Lat <= 4'd4; p1Lat <= 6'd1;
    end else if (cmd.latch) begin
      nLat <= intDiv; modLat <= fracMod; fracLat <= fracNum;
      p0Lat <= postDivA; p1Lat <= postDivB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      spiCsN   <= 1'b1;
      spiSclk  <= 1'b0;
    end else begin
      if (cmd.load) begin
        shiftReg <= nextByte;
        spiCsN   <= 1'b0;
        spiSclk  <= 1'b0;
      end else if (cmd.fall) begin
        shiftReg <= {shiftReg[6:0], 1'b0};
        spiSclk  <= 1'b0;
      end else if (cmd.rise) begin
        spiSclk  <= 1'b1;
      end
      if (cmd.csRelease) spiCsN <= 1'b1;
    end
  end

  assign spiMosi = shiftReg[7];
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    refDouble,
  input  logic    paramOk,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    done,
  output logic    paramErr
);
  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_TAIL, S_GAP} state_t;

  state_t           state;
  logic [TW-1:0]    tickCnt;
  logic             tick;
  logic [TXN_W-1:0] txn;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [1:0]       gapCnt;
  logic             sclkHi;
  logic             lastByte;

  assign tick     = (tickCnt == TW'(HALF_DIV - 1));
  assign lastByte = (byteIdx == ((txn == TXN_W'(STREAM_TXN)) ? 4'd10 : 4'd2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else if (state inside {S_SHIFT, S_TAIL, S_GAP}) tickCnt <= tick ? '0 : tickCnt + 1'b1;
    else tickCnt <= '0;
  end

  always_comb begin
    cmd         = '0;
    cmd.txn     = txn;
    cmd.byteIdx = (state == S_LOAD) ? '0 : byteIdx + 1'b1;
    unique case (state)
      S_IDLE:  cmd.latch = start && paramOk;
      S_LOAD:  cmd.load  = 1'b1;
      S_SHIFT: if (tick) begin
                 if (!sclkHi) cmd.rise = 1'b1;
                 else if (bitCnt == 3'd7 && !lastByte) cmd.load = 1'b1;
                 else cmd.fall = 1'b1;
               end
      S_TAIL:  cmd.csRelease = tick;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; txn <= '0; bitCnt <= '0; byteIdx <= '0; gapCnt <= '0;
      sclkHi <= 1'b0; busy <= 1'b0; done <= 1'b0; paramErr <= 1'b0;
    end else begin
      done     <= 1'b0;
      paramErr <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (paramOk) begin
            busy  <= 1'b1;
            txn   <= refDouble ? TXN_W'(0) : TXN_W'(1);
            state <= S_LOAD;
          end else begin
            paramErr <= 1'b1;
          end
        end
        S_LOAD: begin
          byteIdx <= '0; bitCnt <= '0; sclkHi <= 1'b0; state <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sclkHi) sclkHi <= 1'b1;
          else begin
            sclkHi <= 1'b0;
            if (bitCnt == 3'd7) begin
              bitCnt <= '0;
              if (lastByte) state <= S_TAIL;
              else byteIdx <= byteIdx + 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        S_TAIL: if (tick) begin
          if (txn == TXN_W'(LAST_TXN)) begin
            busy <= 1'b0; done <= 1'b1; state <= S_IDLE;
          end else begin
            gapCnt <= '0; state <= S_GAP;
          end
        end
        S_GAP: if (tick) begin
          gapCnt <= gapCnt + 1'b1;
          if (gapCnt == 2'd3) begin
            txn <= txn + 1'b1; state <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_freq_seq.sv
module pll_freq_seq
  import pll_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        refDouble,
  input  logic [7:0]  intDiv,
  input  logic [19:0] fracMod,
  input  logic [19:0] fracNum,
  input  logic [3:0]  postDivA,
  input  logic [5:0]  postDivB,
  output logic        spiCsN,
  output logic        spiSclk,
  output logic        spiMosi,
  output logic        busy,
  output logic        done,
  output logic        paramErr
);
  seqCmd_t cmd;
  logic    paramOk;

  pll_seq_ctrl #(.HALF_DIV(HALF_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .refDouble(refDouble), .paramOk(paramOk),
    .cmd(cmd), .busy(busy), .done(done), .paramErr(paramErr)
  );

  pll_seq_dp dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .intDiv(intDiv), .fracMod(fracMod),
    .fracNum(fracNum), .postDivA(postDivA), .postDivB(postDivB), .paramOk(paramOk),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi)
  );
endmodule

// File: rtl/pll_freq_seq_chk.sv
module pll_freq_seq_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic paramErr,
  input logic spiCsN,
  input logic spiSclk,
  input logic spiMosi
);
  logic [15:0] hiRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiRun <= '1;
    else if (!spiCsN) hiRun <= '0;
    else if (hiRun != '1) hiRun <= hiRun + 1'b1;
  end

  assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    paramErr |-> (spiCsN && !busy));
  assert_err_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    paramErr |=> !paramErr);
  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);
  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> $stable(spiMosi));
  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> (hiRun >= 16'(4 * HALF_DIV)));
  assert_frame_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> busy);
  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && spiCsN && $rose(spiCsN)));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !paramErr);
endmodule

bind pll_freq_seq pll_freq_seq_chk #(.HALF_DIV(HALF_DIV)) chk_i (.*);

// File: tb/pll_freq_seq_tb_top.sv
module pll_freq_seq_tb_top;
  localparam int HALF = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, refDouble = 1'b0;
  logic [7:0] intDiv = 8'd64;
  logic [19:0] fracMod = '0, fracNum = '0;
  logic [3:0] postDivA = 4'd4;
  logic [5:0] postDivB = 6'd1;
  logic spiCsN, spiSclk, spiMosi, busy, done, paramErr;

  always #4 clk = ~clk;

  pll_freq_seq #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .refDouble(refDouble), .intDiv(intDiv),
    .fracMod(fracMod), .fracNum(fracNum), .postDivA(postDivA), .postDivB(postDivB),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .busy(busy), .done(done),
    .paramErr(paramErr)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [7:0] capB [8][16];
  int capLen [8];
  int capN = 0, capIdx = 0, capBit = 0;
  logic [7:0] curByte = '0;
  logic [7:0] expB [8][16];
  int expLen [8];
  int expN = 0;
  int doneCnt = 0, errCnt = 0, modeBad = 0, hiCnt = 0, minGap = 9999;
  logic prevSclk = 1'b0, prevMosi = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge spiSclk) if (!spiCsN) begin
    curByte = {curByte[6:0], spiMosi};
    capBit++;
    if (capBit == 8) begin
      if (capN < 8 && capIdx < 16) capB[capN][capIdx] = curByte;
      capIdx++;
      capBit = 0;
    end
  end

  always @(posedge spiCsN) if (capIdx != 0 || capBit != 0) begin
    if (capN < 8) capLen[capN] = capIdx;
    capN++;
    capIdx = 0;
    capBit = 0;
  end

  always @(negedge clk) begin
    cycles++;
    if (done) doneCnt++;
    if (paramErr) errCnt++;
    if (spiSclk && prevSclk && spiMosi !== prevMosi) modeBad++;
    if (spiCsN && spiSclk) modeBad++;
    if (spiCsN) hiCnt++;
    else begin
      if (hiCnt > 0 && capN > 0 && hiCnt < minGap) minGap = hiCnt;
      hiCnt = 0;
    end
    prevSclk = spiSclk;
    prevMosi = spiMosi;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cycles, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic addSingle(input logic [7:0] addr, input logic [7:0] data);
    expB[expN][0] = 8'h00; expB[expN][1] = addr; expB[expN][2] = data;
    expLen[expN] = 3; expN++;
  endtask

  task automatic buildExp(input bit k, input logic [7:0] n, input logic [19:0] md,
                          input logic [19:0] fr, input logic [3:0] p0, input logic [5:0] p1);
    logic [3:0] p0c;
    p0c = p0 - 4'd4;
    expN = 0;
    if (k) addSingle(8'h1D, 8'h04);
    addSingle(8'h0E, 8'h74);
    addSingle(8'h05, 8'h01);
    expB[expN][0]  = 8'h60;
    expB[expN][1]  = 8'h19;
    expB[expN][2]  = 8'h80;
    expB[expN][3]  = {p1[4:0], p0c[2:0]};
    expB[expN][4]  = {fr[3:0], 3'b000, p1[5]};
    expB[expN][5]  = fr[11:4];
    expB[expN][6]  = fr[19:12];
    expB[expN][7]  = {md[3:0], (fr == 20'd0) ? 4'hE : 4'h8};
    expB[expN][8]  = md[11:4];
    expB[expN][9]  = md[19:12];
    expB[expN][10] = n;
    expLen[expN] = 11; expN++;
    addSingle(8'h05, 8'h01);
    addSingle(8'h0E, 8'hF4);
    addSingle(8'h05, 8'h01);
  endtask

  task automatic clearCap();
    capN = 0; capIdx = 0; capBit = 0; doneCnt = 0; errCnt = 0; modeBad = 0;
    hiCnt = 0; minGap = 9999;
  endtask

  task automatic runSeq(input bit k, input logic [7:0] n, input logic [19:0] md,
                        input logic [19:0] fr, input logic [3:0] p0, input logic [5:0] p1,
                        input bit inject);
    int t = 0;
    buildExp(k, n, md, fr, p0, p1);
    clearCap();
    @(negedge clk);
    refDouble = k; intDiv = n; fracMod = md; fracNum = fr; postDivA = p0; postDivB = p1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    while (doneCnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (inject && t == 100) begin
        start = 1'b1; refDouble = ~k; intDiv = 8'd250; fracMod = ~md; fracNum = ~fr;
        postDivA = 4'd7; postDivB = 6'd33;
      end else start = 1'b0;
      if (t == 50) chk(busy == 1'b1, "R10 busy mid-sequence", busy, 1);
    end
    start = 1'b0;
    repeat (300) @(negedge clk);
    chk(doneCnt == 1, "R10 done pulse count", doneCnt, 1);
    chk(busy == 1'b0, "R10 busy low at end", busy, 0);
    chk(errCnt == 0, "R1 no error on valid set", errCnt, 0);
    chk(modeBad == 0, "R8 clock/data phase", modeBad, 0);
    chk(minGap >= 4 * HALF, "R9 chip-select gap", minGap, 4 * HALF);
    chk(capN == expN, inject ? "R11 frame count after ignored start" : "R2 R3 frame count",
        capN, expN);
    for (int f = 0; f < expN && f < capN && f < 8; f++) begin
      chk(capLen[f] == expLen[f], "R3 frame length", capLen[f], expLen[f]);
      for (int b = 0; b < expLen[f] && b < 16; b++) begin
        string tag;
        if (expLen[f] == 11) begin
          if (b < 2) tag = "R5 stream header";
          else if (b == 7) tag = "R7 register 0x14";
          else tag = "R6 register byte";
        end else if (expB[f][1] == 8'h05) tag = "R4 commit byte";
        else if (expB[f][1] == 8'h1D) tag = "R2 doubler byte";
        else tag = "R3 calibration byte";
        if (inject) tag = {"R11 ", tag};
        chk(capB[f][b] === expB[f][b], tag, capB[f][b], expB[f][b]);
      end
    end
  endtask

  task automatic runBad(input logic [7:0] n, input logic [3:0] p0, input logic [5:0] p1,
                        input string why);
    clearCap();
    @(negedge clk);
    refDouble = 1'b1; intDiv = n; fracMod = 20'h12345; fracNum = 20'h00F0F;
    postDivA = p0; postDivB = p1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(errCnt == 1, {"R1 error pulse ", why}, errCnt, 1);
    chk(capN == 0 && spiCsN == 1'b1, {"R1 no frame ", why}, capN, 0);
    chk(busy == 1'b0, {"R1 busy stays low ", why}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spiCsN == 1'b1, "R10 reset chip select", spiCsN, 1);
    chk(spiSclk == 1'b0, "R8 reset clock idle", spiSclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {busy, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runBad(8'd100, 4'd3, 6'd5, "P0 low");
    runBad(8'd100, 4'd12, 6'd5, "P0 high");
    runBad(8'd100, 4'd15, 6'd5, "P0 max");
    runBad(8'd100, 4'd6, 6'd0, "P1 zero");
    runBad(8'd63, 4'd6, 6'd5, "N low");

    for (int k = 0; k < 2; k++)
      for (int p0 = 4; p0 <= 11; p0++)
        for (int fz = 0; fz < 2; fz++) begin
          logic [7:0] n;
          logic [5:0] p1;
          logic [19:0] md, fr;
          n  = (p0 == 5) ? 8'd64 : 8'(64 + p0 * 13 + k * 3 + fz);
          p1 = 6'(1 + ((p0 * 7 + k * 31 + fz * 17) % 63));
          if (p0 == 4) p1 = 6'd1;
          if (p0 == 11) p1 = 6'd63;
          md = 20'hA5C3E ^ 20'(p0 << 12) ^ 20'(k * 5 + fz);
          fr = fz ? 20'd0 : 20'(20'h12345 + p0 * 777 + k);
          runSeq(k[0], n, md, fr, 4'(p0), p1, 1'b0);
        end

    runSeq(1'b1, 8'd255, 20'hFFFFF, 20'hFFFFF, 4'd9, 6'd40, 1'b1);
    runSeq(1'b0, 8'd150, 20'h00001, 20'd0, 4'd8, 6'd32, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule